// File: doc/BRIEF.md
# Timer Compare Output Unit

This unit holds a 16-bit compare value and checks it against a free-running 16-bit timer that is supplied from outside. When the two become equal, the unit applies the action chosen by a 4-bit mode code to a single output latch that drives a pin. The action is one of: force the latch high, force it low, invert it, or leave it alone. The same event sets an interrupt flag, and only software clears that flag.

Writing certain mode codes also preloads the latch straight away, so the pin starts at a known level before the first match. Writing the all-zero code switches the unit off and pulls the latch low. The timer, the pin direction control and the port data latch belong to other blocks.

The mode is kept as an enumerated state. There are five states:

| State | Code | What a match does |
|---|---|---|
| `M_OFF` | 0000 or any code not listed below | nothing |
| `M_DRIVE_HI` | 1000 | drives the latch high |
| `M_DRIVE_LO` | 1001 | drives the latch low |
| `M_TOGGLE` | 0010 | inverts the latch |
| `M_FLAG_ONLY` | 1010 | sets the flag only |

There is one transition: from any state to the state that the written code decodes to, taken on `mode_wr`. Without a write, every state stays where it is.

Top module: `tcmp_unit`

## Requirements
- R1: After reset, `out_pin` is 0, `cmp_flag` is 0, the mode is `M_OFF` and the compare register holds 0.
- R2: A clock edge with `cmp_wr` high loads `cmp_wdata` into the compare register. A match is an equality between `tmr_val` and that register.
- R3: A match is acted on only in the first cycle of equality. If `tmr_val` stays equal over later cycles, no further action is taken until equality has ended and starts again.
- R4: Writing code 1000 sets `out_pin` to 1 on the next cycle. In that mode, a match drives `out_pin` to 1.
- R5: Writing code 1001 sets `out_pin` to 0 on the next cycle. In that mode, a match drives `out_pin` to 0.
- R6: In code 0010, a match inverts `out_pin`. Writing this code leaves `out_pin` unchanged.
- R7: In code 1010, a match sets `cmp_flag` and leaves `out_pin` unchanged. Writing this code leaves `out_pin` unchanged.
- R8: Writing code 0000 forces `out_pin` to 0 on the next cycle.
- R9: In `M_OFF`, whether entered by code 0000 or by any code not listed above, a match neither sets `cmp_flag` nor changes `out_pin`. Writing an unlisted code leaves `out_pin` unchanged.
- R10: A match in any active mode sets `cmp_flag` on the same edge as the latch action. The flag stays set until a cycle with `flag_clr` high and no match. When a match and `flag_clr` fall in the same cycle, the set wins.
- R11: A match that arrives in the same cycle as a mode write is discarded. The latch takes only the preload or hold of the write, and the flag does not set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tmr_val | input | 16 | Current timer count |
| cmp_wr | input | 1 | Compare register write strobe |
| cmp_wdata | input | 16 | Compare register write data |
| mode_wr | input | 1 | Mode write strobe |
| mode_wdata | input | 4 | Mode code to write |
| flag_clr | input | 1 | Software clear of the interrupt flag |
| out_pin | output | 1 | Compare output latch |
| cmp_flag | output | 1 | Match interrupt flag |

## Verification
The assertions assume that every input is stable around the rising clock edge. They also assume that a cycle with `mode_wr` high has its own meaning, so properties about the match action exclude those cycles rather than assume such cycles never happen. The stimulus changes every input on the falling edge only. It steps `tmr_val` up to, across and back onto the compare value, and it holds the timer on the compare value for several cycles. It also deliberately places a mode write and a flag clear in the same cycle as a match, so that the priority rules are exercised and not avoided.

// File: rtl/tcmp_pkg.sv
package tcmp_pkg;

    localparam int MODE_W = 4;

    localparam logic [MODE_W-1:0] CODE_OFF     = 4'b0000;
    localparam logic [MODE_W-1:0] CODE_TOGGLE  = 4'b0010;
    localparam logic [MODE_W-1:0] CODE_HI      = 4'b1000;
    localparam logic [MODE_W-1:0] CODE_LO      = 4'b1001;
    localparam logic [MODE_W-1:0] CODE_FLAGONL = 4'b1010;

    typedef enum logic [2:0] {
        M_OFF,
        M_DRIVE_HI,
        M_DRIVE_LO,
        M_TOGGLE,
        M_FLAG_ONLY
    } cmp_mode_e;

    function automatic cmp_mode_e decode_mode(input logic [MODE_W-1:0] code);
        cmp_mode_e m;
        unique case (code)
            CODE_HI:      m = M_DRIVE_HI;
            CODE_LO:      m = M_DRIVE_LO;
            CODE_TOGGLE:  m = M_TOGGLE;
            CODE_FLAGONL: m = M_FLAG_ONLY;
            default:      m = M_OFF;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/tcmp_edge.sv
module tcmp_edge #(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [TW-1:0] tmr_val,
    input  logic          cmp_wr,
    input  logic [TW-1:0] cmp_wdata,
    output logic          match_pulse
);

    logic [TW-1:0] cmp_q;
    logic          eq_now;
    logic          eq_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmp_q <= '0;
        end else if (cmp_wr) begin
            cmp_q <= cmp_wdata;
        end
    end

    always_comb eq_now = (tmr_val == cmp_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            eq_q <= 1'b0;
        end else begin
            eq_q <= eq_now;
        end
    end

    always_comb match_pulse = eq_now & ~eq_q;

endmodule

// File: rtl/tcmp_mode_fsm.sv
module tcmp_mode_fsm
    import tcmp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_wr,
    input  logic [MODE_W-1:0] mode_wdata,
    output cmp_mode_e         cur_mode,
    output logic              preset_en,
    output logic              preset_val
);

    cmp_mode_e state_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= M_OFF;
        end else if (mode_wr) begin
            state_q <= decode_mode(mode_wdata);
        end
    end

    always_comb begin
        cur_mode   = state_q;
        preset_en  = 1'b0;
        preset_val = 1'b0;
        if (mode_wr) begin
            unique case (mode_wdata)
                CODE_HI: begin
                    preset_en  = 1'b1;
                    preset_val = 1'b1;
                end
                CODE_LO, CODE_OFF: begin
                    preset_en  = 1'b1;
                    preset_val = 1'b0;
                end
                default: begin
                    preset_en  = 1'b0;
                    preset_val = 1'b0;
                end
            endcase
        end
    end

endmodule

// File: rtl/tcmp_out_stage.sv
module tcmp_out_stage
    import tcmp_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  cmp_mode_e cur_mode,
    input  logic      mode_wr,
    input  logic      preset_en,
    input  logic      preset_val,
    input  logic      match_pulse,
    input  logic      flag_clr,
    output logic      out_pin,
    output logic      cmp_flag
);

    logic act;

    always_comb act = match_pulse && !mode_wr && (cur_mode != M_OFF);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_pin <= 1'b0;
        end else if (mode_wr) begin
            if (preset_en) begin
                out_pin <= preset_val;
            end
        end else if (act) begin
            unique case (cur_mode)
                M_DRIVE_HI:  out_pin <= 1'b1;
                M_DRIVE_LO:  out_pin <= 1'b0;
                M_TOGGLE:    out_pin <= ~out_pin;
                default:     out_pin <= out_pin;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmp_flag <= 1'b0;
        end else if (act) begin
            cmp_flag <= 1'b1;
        end else if (flag_clr) begin
            cmp_flag <= 1'b0;
        end
    end

endmodule

// File: rtl/tcmp_unit.sv
module tcmp_unit
    import tcmp_pkg::*;
#(
    parameter int TW = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TW-1:0]     tmr_val,
    input  logic              cmp_wr,
    input  logic [TW-1:0]     cmp_wdata,
    input  logic              mode_wr,
    input  logic [MODE_W-1:0] mode_wdata,
    input  logic              flag_clr,
    output logic              out_pin,
    output logic              cmp_flag
);

    logic      match_pulse;
    cmp_mode_e cur_mode;
    logic      preset_en;
    logic      preset_val;

    tcmp_edge #(.TW(TW)) u_edge (
        .clk         (clk),
        .rst_n       (rst_n),
        .tmr_val     (tmr_val),
        .cmp_wr      (cmp_wr),
        .cmp_wdata   (cmp_wdata),
        .match_pulse (match_pulse)
    );

    tcmp_mode_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_wr    (mode_wr),
        .mode_wdata (mode_wdata),
        .cur_mode   (cur_mode),
        .preset_en  (preset_en),
        .preset_val (preset_val)
    );

    tcmp_out_stage u_out (
        .clk         (clk),
        .rst_n       (rst_n),
        .cur_mode    (cur_mode),
        .mode_wr     (mode_wr),
        .preset_en   (preset_en),
        .preset_val  (preset_val),
        .match_pulse (match_pulse),
        .flag_clr    (flag_clr),
        .out_pin     (out_pin),
        .cmp_flag    (cmp_flag)
    );

endmodule

// File: rtl/tcmp_unit_chk.sv
module tcmp_unit_chk
    import tcmp_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              mode_wr,
    input logic [MODE_W-1:0] mode_wdata,
    input logic              flag_clr,
    input logic              out_pin,
    input logic              cmp_flag,
    input logic              match_pulse,
    input cmp_mode_e         cur_mode
);

    p_preset_hi_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mode_wr && mode_wdata == 4'b1000 |=> out_pin);

    p_preset_lo_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mode_wr && mode_wdata == 4'b1001 |=> !out_pin);

    p_toggle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        match_pulse && !mode_wr && cur_mode == M_TOGGLE |=> out_pin != $past(out_pin));

    p_clear_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mode_wr && mode_wdata == 4'b0000 |=> !out_pin);

    p_off_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cur_mode == M_OFF && !mode_wr |=> $stable(out_pin) && !$rose(cmp_flag));

    p_flag_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
        match_pulse && !mode_wr && cur_mode != M_OFF |=> cmp_flag);

    p_flag_clear_only_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cmp_flag) |-> $past(flag_clr));

    p_write_discard_r11: assert property (@(posedge clk) disable iff (!rst_n)
        mode_wr |=> !$rose(cmp_flag));

endmodule

bind tcmp_unit tcmp_unit_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_wr     (mode_wr),
    .mode_wdata  (mode_wdata),
    .flag_clr    (flag_clr),
    .out_pin     (out_pin),
    .cmp_flag    (cmp_flag),
    .match_pulse (match_pulse),
    .cur_mode    (cur_mode)
);

// File: tb/tcmp_unit_test.sv
module tcmp_unit_test;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] tmr_val = '0;
    logic        cmp_wr = 1'b0;
    logic [15:0] cmp_wdata = '0;
    logic        mode_wr = 1'b0;
    logic [3:0]  mode_wdata = '0;
    logic        flag_clr = 1'b0;
    logic        out_pin;
    logic        cmp_flag;

    int checks = 0;
    int errors = 0;
    bit summary_done = 1'b0;

    typedef struct {
        logic  o;
        logic  f;
        string tag;
    } exp_t;

    exp_t sb_q[$];

    // reference state, derived from the requirements
    logic [15:0] m_cmp = '0;
    logic        m_eqq = 1'b0;
    logic [3:0]  m_mode = 4'b0000;
    logic        m_out = 1'b0;
    logic        m_flag = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tcmp_unit uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .tmr_val    (tmr_val),
        .cmp_wr     (cmp_wr),
        .cmp_wdata  (cmp_wdata),
        .mode_wr    (mode_wr),
        .mode_wdata (mode_wdata),
        .flag_clr   (flag_clr),
        .out_pin    (out_pin),
        .cmp_flag   (cmp_flag)
    );

    function automatic bit active(input logic [3:0] c);
        return c == 4'b1000 || c == 4'b1001 || c == 4'b0010 || c == 4'b1010;
    endfunction

    task automatic step(input logic [15:0] t, input logic cw, input logic [15:0] cd,
                        input logic mw, input logic [3:0] md, input logic fc,
                        input string tag);
        logic eq;
        logic mt;
        exp_t e;
        @(negedge clk);
        tmr_val = t; cmp_wr = cw; cmp_wdata = cd;
        mode_wr = mw; mode_wdata = md; flag_clr = fc;
        eq = (t == m_cmp);
        mt = eq && !m_eqq;
        if (mw) begin
            if (md == 4'b1000) m_out = 1'b1;
            else if (md == 4'b1001 || md == 4'b0000) m_out = 1'b0;
            if (fc) m_flag = 1'b0;
            m_mode = md;
        end else if (mt && active(m_mode)) begin
            if (m_mode == 4'b1000) m_out = 1'b1;
            else if (m_mode == 4'b1001) m_out = 1'b0;
            else if (m_mode == 4'b0010) m_out = ~m_out;
            m_flag = 1'b1;
        end else if (fc) begin
            m_flag = 1'b0;
        end
        m_eqq = eq;
        if (cw) m_cmp = cd;
        e.o = m_out; e.f = m_flag; e.tag = tag;
        sb_q.push_back(e);
    endtask

    task automatic idle(input logic [15:0] t, input string tag);
        step(t, 1'b0, 16'h0, 1'b0, 4'h0, 1'b0, tag);
    endtask

    task automatic summary();
        if (!summary_done) begin
            summary_done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
        end
    endtask

    // monitor: compares outputs one step after each driven cycle
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                checks++;
                if (out_pin !== e.o || cmp_flag !== e.f) begin
                    errors++;
                    $display("FAIL %s: out_pin=%b cmp_flag=%b expected out_pin=%b cmp_flag=%b",
                             e.tag, out_pin, cmp_flag, e.o, e.f);
                end
            end
        end
    end

    // watchdog
    initial begin
        #(CLK_PERIOD * 5000);
        errors++;
        $display("FAIL watchdog: run did not finish, expected completion");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if (out_pin !== 1'b0 || cmp_flag !== 1'b0) begin
            errors++;
            $display("FAIL R1 reset: out_pin=%b cmp_flag=%b expected 0 0", out_pin, cmp_flag);
        end
        idle(16'd0, "R1 off mode ignores match on reset value 0");

        // R2: load compare value
        step(16'd50, 1'b1, 16'd100, 1'b0, 4'h0, 1'b0, "R2 load compare");
        // R6: toggle mode, write does not preset
        step(16'd98, 1'b0, 16'h0, 1'b1, 4'b0010, 1'b0, "R6 toggle write holds latch");
        idle(16'd99, "R2 no match below compare");
        idle(16'd100, "R6 toggle on match");
        idle(16'd100, "R3 held equality no retoggle");
        idle(16'd100, "R3 held equality no retoggle 2");
        step(16'd101, 1'b0, 16'h0, 1'b0, 4'h0, 1'b1, "R10 flag clear");
        idle(16'd100, "R6 second toggle");
        step(16'd101, 1'b0, 16'h0, 1'b0, 4'h0, 1'b1, "R10 flag clear again");
        step(16'd100, 1'b0, 16'h0, 1'b0, 4'h0, 1'b1, "R10 set beats clear");
        step(16'd101, 1'b0, 16'h0, 1'b0, 4'h0, 1'b1, "R10 flag clear");

        // R4: drive high
        step(16'd101, 1'b0, 16'h0, 1'b1, 4'b1000, 1'b0, "R4 preset high");
        idle(16'd100, "R4 match drives high");
        step(16'd101, 1'b0, 16'h0, 1'b0, 4'h0, 1'b1, "R10 flag clear");

        // R7: flag only, latch high stays
        step(16'd101, 1'b0, 16'h0, 1'b1, 4'b1010, 1'b0, "R7 write holds latch");
        idle(16'd100, "R7 match sets flag only");
        step(16'd101, 1'b0, 16'h0, 1'b0, 4'h0, 1'b1, "R10 flag clear");

        // R5: drive low
        step(16'd101, 1'b0, 16'h0, 1'b1, 4'b1001, 1'b0, "R5 preset low");
        idle(16'd100, "R5 match drives low");
        step(16'd101, 1'b0, 16'h0, 1'b0, 4'h0, 1'b1, "R10 flag clear");

        // R2: new compare value
        step(16'd200, 1'b1, 16'd300, 1'b1, 4'b0010, 1'b0, "R2 reload compare");
        idle(16'd100, "R2 old value no longer matches");
        idle(16'd300, "R2 new value toggles");
        step(16'd301, 1'b0, 16'h0, 1'b0, 4'h0, 1'b1, "R10 flag clear");

        // R8: off forces low
        step(16'd301, 1'b0, 16'h0, 1'b1, 4'b0000, 1'b0, "R8 off forces low");
        idle(16'd300, "R9 off ignores match");
        idle(16'd301, "R9 off idle");

        // R9: unlisted code holds latch and ignores match
        step(16'd301, 1'b0, 16'h0, 1'b1, 4'b1000, 1'b0, "R4 preset high again");
        step(16'd301, 1'b0, 16'h0, 1'b1, 4'b0111, 1'b0, "R9 unlisted code holds latch");
        idle(16'd300, "R9 unlisted code ignores match");
        idle(16'd301, "R9 idle");

        // R11: mode write during match
        step(16'd299, 1'b0, 16'h0, 1'b1, 4'b0010, 1'b0, "R11 set toggle");
        step(16'd300, 1'b0, 16'h0, 1'b1, 4'b1001, 1'b0, "R11 write wins over match");
        idle(16'd300, "R11 held equality no late action");
        idle(16'd301, "R11 idle");
        step(16'd300, 1'b0, 16'h0, 1'b1, 4'b1000, 1'b0, "R11 preset high wins over match");
        idle(16'd301, "R11 idle after");

        @(posedge clk);
        #3;
        if (sb_q.size() != 0) begin
            errors++;
            $display("FAIL scoreboard: %0d items left, expected 0", sb_q.size());
        end
        summary();
        $finish;
    end

endmodule